// File: doc/BRIEF.md
# Result Store Cycle Sequencer

This block runs the store phase of a 36-bit accumulator processor. It takes over when the execute phase finishes and first settles the memory operand. It does this by issuing a fresh memory write, by restarting a read-write cycle that the fetch phase left paused, or by skipping memory altogether. It then writes the result into one accumulator, or into an accumulator pair, inside the 16-word fast-register space. Finally it hands control either to the next instruction cycle or to a front-panel key cycle.

The sequencer parks on each memory request and waits for a single memory-done strobe. Three separate return flags record which step a completion belongs to, and they are examined in a fixed priority. Instruction decoding, the arithmetic registers and the memory itself lie outside the block. The qualifiers, the AR and MQ values, the entry address and data, and the key state are inputs that must stay steady while a store sequence runs.

Top module: `store_seq`

## Requirements
- R1: When `exec_done` pulses and `store_mem` is high, the block raises `wr_req` for one cycle with `mem_addr` equal to `entry_addr` and `mem_data` equal to `entry_data`. This takes priority over `fetch_paused`.
- R2: When `exec_done` pulses with `store_mem` low and `fetch_paused` high, the block raises `restart_req` for one cycle and no write request.
- R3: When `exec_done` pulses with both `store_mem` and `fetch_paused` low, no memory request is made before the accumulator decision.
- R4: With `ac_inhibit` high, no accumulator write is issued and the sequence goes straight to the final step.
- R5: The accumulator write puts `mem_addr` at the 4-bit `ac_field` with all upper address bits zero and `mem_data` equal to `ar`.
- R6: With `ac_pair` high, a second write follows the first one's completion. It uses address (`ac_field`+1) mod 16 with zero upper bits and data equal to `mq`, so field 15 wraps to address 0.
- R7: With `ac_pair` low, the completion of the accumulator write leads directly to the final step with no further write.
- R8: In the final step with `run` high, `go_key_rw` pulses if `key_exam` or `key_dep` is high, otherwise `go_inst` pulses. With `run` low, neither pulses.
- R9: In the final step, `go_key_start` pulses whenever `key_start`, `key_readin` or `key_cont` is high, regardless of `run`.
- R10: At most one return flag is set at a time. A `mem_done` strobe while no request is outstanding produces no output activity.
- R11: After reset, all request and dispatch outputs are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_done | input | 1 | One-cycle pulse: execute finished, begin store |
| store_mem | input | 1 | Qualifier: write the memory operand |
| fetch_paused | input | 1 | Qualifier: fetch left a read-write cycle paused |
| ac_inhibit | input | 1 | Qualifier: suppress accumulator store |
| ac_pair | input | 1 | Qualifier: also store MQ into the next accumulator |
| entry_addr | input | AW | Memory operand address at entry |
| entry_data | input | DW | Memory operand data at entry |
| ar | input | DW | Primary result |
| mq | input | DW | Secondary result |
| ac_field | input | FRW | Accumulator number from the instruction |
| run | input | 1 | Processor running |
| key_exam | input | 1 | Examine key cycle active |
| key_dep | input | 1 | Deposit key cycle active |
| key_start | input | 1 | Start key active |
| key_readin | input | 1 | Read-in key active |
| key_cont | input | 1 | Continue key active |
| mem_done | input | 1 | Memory completion strobe |
| mem_addr | output | AW | Address register |
| mem_data | output | DW | Memory buffer data |
| wr_req | output | 1 | Write request pulse |
| restart_req | output | 1 | Restart paused read-write cycle pulse |
| go_inst | output | 1 | Enter instruction cycle pulse |
| go_key_rw | output | 1 | Enter examine/deposit key cycle pulse |
| go_key_start | output | 1 | Enter start/read-in/continue key cycle pulse |

## Verification
The bench targets the pair write at field 15. A design that carried into bit 4 would write address 16 instead of 0. It also runs both entry qualifiers together, where a wrong priority would emit a restart, or both a restart and a write. It uses cases with inhibit and with run low, where a design that ignored them would write an accumulator or dispatch to the instruction cycle. A stray completion strobe while idle checks that a stale flag cannot restart the sequence.

// File: rtl/store_pkg.sv
package store_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DECIDE,
    ST_BRIDGE,
    ST_ACWR,
    ST_POSTAC,
    ST_PAIR,
    ST_FINAL
  } seq_state_t;
endpackage

// File: rtl/store_flags.sv
module store_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_dec,
  input  logic set_acw,
  input  logic set_fin,
  input  logic clr_dec,
  input  logic clr_acw,
  input  logic clr_fin,
  input  logic mem_done,
  output logic res_dec,
  output logic res_acw,
  output logic res_fin
);
  logic f_dec, f_acw, f_fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_dec <= 1'b0;
      f_acw <= 1'b0;
      f_fin <= 1'b0;
    end else begin
      if (set_dec) f_dec <= 1'b1; else if (clr_dec) f_dec <= 1'b0;
      if (set_acw) f_acw <= 1'b1; else if (clr_acw) f_acw <= 1'b0;
      if (set_fin) f_fin <= 1'b1; else if (clr_fin) f_fin <= 1'b0;
    end
  end

  // fixed priority: final, then post-AC, then decision
  always_comb begin
    res_fin = mem_done & f_fin;
    res_acw = mem_done & f_acw & ~f_fin;
    res_dec = mem_done & f_dec & ~f_fin & ~f_acw;
  end

  p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({f_dec, f_acw, f_fin}));

  p_set_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_dec, set_acw, set_fin}));
endmodule

// File: rtl/store_addr.sv
module store_addr #(
  parameter int AW  = 18,
  parameter int DW  = 36,
  parameter int FRW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_entry,
  input  logic [AW-1:0] entry_addr,
  input  logic [DW-1:0] entry_data,
  input  logic          clr_addr,
  input  logic          or_ac,
  input  logic [FRW-1:0] ac_field,
  input  logic          inc_pair,
  input  logic          ld_ar,
  input  logic          ld_mq,
  input  logic [DW-1:0] ar,
  input  logic [DW-1:0] mq,
  output logic [AW-1:0] ma,
  output logic [DW-1:0] mb
);
  localparam int UPW = AW - FRW;

  function automatic logic [AW-1:0] with_ac(input logic [AW-1:0] a,
                                            input logic [FRW-1:0] f);
    return a | {{UPW{1'b0}}, f};
  endfunction

  // increment confined to the fast-register window, upper bits cleared
  function automatic logic [AW-1:0] pair_next(input logic [AW-1:0] a);
    logic [FRW-1:0] lo;
    lo = a[FRW-1:0] + 1'b1;
    return {{UPW{1'b0}}, lo};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma <= '0;
      mb <= '0;
    end else begin
      if (load_entry)     ma <= entry_addr;
      else if (clr_addr)  ma <= '0;
      else if (or_ac)     ma <= with_ac(ma, ac_field);
      else if (inc_pair)  ma <= pair_next(ma);

      if (load_entry)     mb <= entry_data;
      else if (ld_ar)     mb <= ar;
      else if (ld_mq)     mb <= mq;
    end
  end

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_addr |=> (ma == '0));

  p_pair_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pair |=> (ma[FRW-1:0] == FRW'($past(ma[FRW-1:0]) + 1'b1)) &&
                 (ma[AW-1:FRW] == '0));
endmodule

// File: rtl/store_ctrl.sv
module store_ctrl
  import store_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exec_done,
  input  logic store_mem,
  input  logic fetch_paused,
  input  logic ac_inhibit,
  input  logic ac_pair,
  input  logic run,
  input  logic key_exam,
  input  logic key_dep,
  input  logic key_start,
  input  logic key_readin,
  input  logic key_cont,
  input  logic res_dec,
  input  logic res_acw,
  input  logic res_fin,
  output logic set_dec,
  output logic set_acw,
  output logic set_fin,
  output logic clr_dec,
  output logic clr_acw,
  output logic clr_fin,
  output logic load_entry,
  output logic clr_addr,
  output logic or_ac,
  output logic inc_pair,
  output logic ld_ar,
  output logic ld_mq,
  output logic wr_req,
  output logic restart_req,
  output logic go_inst,
  output logic go_key_rw,
  output logic go_key_start
);
  seq_state_t state, nxt;
  logic fire_wr, fire_rs, fire_inst, fire_krw, fire_kst;

  always_comb begin
    nxt = state;
    {set_dec, set_acw, set_fin, clr_dec, clr_acw, clr_fin} = '0;
    {load_entry, clr_addr, or_ac, inc_pair, ld_ar, ld_mq} = '0;
    {fire_wr, fire_rs, fire_inst, fire_krw, fire_kst} = '0;
    unique case (state)
      ST_IDLE: if (exec_done) begin
        load_entry = 1'b1;
        if (store_mem) begin
          fire_wr = 1'b1; set_dec = 1'b1; nxt = ST_WAIT;
        end else if (fetch_paused) begin
          fire_rs = 1'b1; set_dec = 1'b1; nxt = ST_WAIT;
        end else begin
          nxt = ST_DECIDE;
        end
      end
      ST_WAIT: begin
        if (res_fin)      nxt = ST_FINAL;
        else if (res_acw) nxt = ST_POSTAC;
        else if (res_dec) nxt = ST_DECIDE;
      end
      ST_DECIDE: begin
        clr_dec = 1'b1;
        if (ac_inhibit) nxt = ST_FINAL;
        else begin
          clr_addr = 1'b1; nxt = ST_BRIDGE;
        end
      end
      ST_BRIDGE: nxt = ST_ACWR;
      ST_ACWR: begin
        set_acw = 1'b1; or_ac = 1'b1; ld_ar = 1'b1; fire_wr = 1'b1;
        nxt = ST_WAIT;
      end
      ST_POSTAC: begin
        clr_acw = 1'b1;
        nxt = ac_pair ? ST_PAIR : ST_FINAL;
      end
      ST_PAIR: begin
        inc_pair = 1'b1; ld_mq = 1'b1; set_fin = 1'b1; fire_wr = 1'b1;
        nxt = ST_WAIT;
      end
      ST_FINAL: begin
        clr_fin = 1'b1;
        if (run) begin
          if (key_exam || key_dep) fire_krw = 1'b1;
          else                     fire_inst = 1'b1;
        end
        if (key_start || key_readin || key_cont) fire_kst = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      wr_req       <= 1'b0;
      restart_req  <= 1'b0;
      go_inst      <= 1'b0;
      go_key_rw    <= 1'b0;
      go_key_start <= 1'b0;
    end else begin
      state        <= nxt;
      wr_req       <= fire_wr;
      restart_req  <= fire_rs;
      go_inst      <= fire_inst;
      go_key_rw    <= fire_krw;
      go_key_start <= fire_kst;
    end
  end

  p_req_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && restart_req));

  p_go_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_inst && go_key_rw));

  p_go_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_inst || go_key_rw) |-> $past(run));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !exec_done) |=> !(wr_req || restart_req));
endmodule

// File: rtl/store_seq.sv
module store_seq #(
  parameter int AW  = 18,
  parameter int DW  = 36,
  parameter int FRW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_done,
  input  logic           store_mem,
  input  logic           fetch_paused,
  input  logic           ac_inhibit,
  input  logic           ac_pair,
  input  logic [AW-1:0]  entry_addr,
  input  logic [DW-1:0]  entry_data,
  input  logic [DW-1:0]  ar,
  input  logic [DW-1:0]  mq,
  input  logic [FRW-1:0] ac_field,
  input  logic           run,
  input  logic           key_exam,
  input  logic           key_dep,
  input  logic           key_start,
  input  logic           key_readin,
  input  logic           key_cont,
  input  logic           mem_done,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  output logic           wr_req,
  output logic           restart_req,
  output logic           go_inst,
  output logic           go_key_rw,
  output logic           go_key_start
);
  logic set_dec, set_acw, set_fin, clr_dec, clr_acw, clr_fin;
  logic res_dec, res_acw, res_fin;
  logic load_entry, clr_addr, or_ac, inc_pair, ld_ar, ld_mq;

  store_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .exec_done(exec_done),
    .store_mem(store_mem), .fetch_paused(fetch_paused),
    .ac_inhibit(ac_inhibit), .ac_pair(ac_pair), .run(run),
    .key_exam(key_exam), .key_dep(key_dep), .key_start(key_start),
    .key_readin(key_readin), .key_cont(key_cont),
    .res_dec(res_dec), .res_acw(res_acw), .res_fin(res_fin),
    .set_dec(set_dec), .set_acw(set_acw), .set_fin(set_fin),
    .clr_dec(clr_dec), .clr_acw(clr_acw), .clr_fin(clr_fin),
    .load_entry(load_entry), .clr_addr(clr_addr), .or_ac(or_ac),
    .inc_pair(inc_pair), .ld_ar(ld_ar), .ld_mq(ld_mq),
    .wr_req(wr_req), .restart_req(restart_req), .go_inst(go_inst),
    .go_key_rw(go_key_rw), .go_key_start(go_key_start)
  );

  store_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_dec(set_dec), .set_acw(set_acw), .set_fin(set_fin),
    .clr_dec(clr_dec), .clr_acw(clr_acw), .clr_fin(clr_fin),
    .mem_done(mem_done),
    .res_dec(res_dec), .res_acw(res_acw), .res_fin(res_fin)
  );

  store_addr #(.AW(AW), .DW(DW), .FRW(FRW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_entry(load_entry),
    .entry_addr(entry_addr), .entry_data(entry_data),
    .clr_addr(clr_addr), .or_ac(or_ac), .ac_field(ac_field),
    .inc_pair(inc_pair), .ld_ar(ld_ar), .ld_mq(ld_mq),
    .ar(ar), .mq(mq), .ma(mem_addr), .mb(mem_data)
  );

  p_ac_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    or_ac |=> wr_req && (mem_data == $past(ar)));
endmodule

// File: tb/store_seq_tb.sv
module store_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18, DW = 36, FRW = 4, LAT = 3;
  localparam int EVW = 3 + AW + DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exec_done = 0, store_mem = 0, fetch_paused = 0, ac_inhibit = 0, ac_pair = 0;
  logic [AW-1:0] entry_addr = '0;
  logic [DW-1:0] entry_data = '0, ar = '0, mq = '0;
  logic [FRW-1:0] ac_field = '0;
  logic run = 0, key_exam = 0, key_dep = 0, key_start = 0, key_readin = 0, key_cont = 0;
  logic mem_done_m = 0, stray = 0;
  logic mem_done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic wr_req, restart_req, go_inst, go_key_rw, go_key_start;
  int checks = 0, fails = 0, pend = 0, cyc = 0;
  logic [EVW-1:0] obs[$];
  logic [EVW-1:0] exp_q[$];

  assign mem_done = mem_done_m | stray;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_seq #(.AW(AW), .DW(DW), .FRW(FRW)) u_dut (.*);

  function automatic logic [EVW-1:0] ev(input int k, input logic [AW-1:0] a,
                                        input logic [DW-1:0] d);
    return {3'(k), a, d};
  endfunction

  // behavioural memory: completes each request LAT cycles later
  always @(negedge clk) begin
    mem_done_m <= 1'b0;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) mem_done_m <= 1'b1;
    end
    if (rst_n && (wr_req || restart_req)) pend <= LAT;
  end

  // event recorder
  always @(negedge clk) if (rst_n) begin
    if (wr_req)       obs.push_back(ev(1, mem_addr, mem_data));
    if (restart_req)  obs.push_back(ev(2, '0, '0));
    if (go_inst)      obs.push_back(ev(3, '0, '0));
    if (go_key_rw)    obs.push_back(ev(4, '0, '0));
    if (go_key_start) obs.push_back(ev(5, '0, '0));
  end

  task automatic check(input bit ok, input string req, input logic [EVW-1:0] act,
                       input logic [EVW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run_case(input string req, input bit sm, input bit ps, input bit inh,
                          input bit pr, input logic [FRW-1:0] ac, input bit rn,
                          input bit ex, input bit dp, input int kst, input int seed);
    logic [AW-1:0] ea;
    logic [DW-1:0] ed, a, m;
    int n;
    ea = AW'(32'h2a5c3 + seed * 977);
    ed = {4'h9, 32'(seed * 32'h01234567)};
    a  = {4'h5, 32'(seed * 32'h89abcdef + 1)};
    m  = {4'hc, 32'(seed * 32'h13572468 + 7)};
    exp_q.delete();
    obs.delete();
    if (sm)      exp_q.push_back(ev(1, ea, ed));
    else if (ps) exp_q.push_back(ev(2, '0, '0));
    if (!inh) begin
      exp_q.push_back(ev(1, AW'(ac), a));
      if (pr) exp_q.push_back(ev(1, AW'(FRW'(ac + 1'b1)), m));
    end
    if (rn) exp_q.push_back(ev((ex || dp) ? 4 : 3, '0, '0));
    if (kst != 0) exp_q.push_back(ev(5, '0, '0));
    @(negedge clk);
    store_mem = sm; fetch_paused = ps; ac_inhibit = inh; ac_pair = pr;
    ac_field = ac; run = rn; key_exam = ex; key_dep = dp;
    key_start = (kst == 1); key_readin = (kst == 2); key_cont = (kst == 3);
    entry_addr = ea; entry_data = ed; ar = a; mq = m;
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    repeat (40) @(negedge clk);
    n = exp_q.size();
    check(obs.size() == n, {req, " event count"}, EVW'(obs.size()), EVW'(n));
    for (int i = 0; i < n && i < obs.size(); i++)
      check(obs[i] === exp_q[i], req, obs[i], exp_q[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({wr_req, restart_req, go_inst, go_key_rw, go_key_start} == 0, "R11 reset",
          EVW'({wr_req, restart_req, go_inst, go_key_rw, go_key_start}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check({wr_req, restart_req, go_inst, go_key_rw, go_key_start} == 0 && mem_addr == 0,
          "R11 idle", EVW'(mem_addr), '0);
    run_case("R1 R5 R7 R8 store-E single AC", 1, 0, 0, 0, 4'd5, 1, 0, 0, 0, 1);
    run_case("R2 R4 restart inhibited",       0, 1, 1, 0, 4'd3, 1, 0, 0, 0, 2);
    run_case("R3 R6 pair wrap at 15",         0, 0, 0, 1, 4'd15, 1, 0, 0, 0, 3);
    run_case("R8 R6 examine key",             1, 0, 0, 1, 4'd7, 1, 1, 0, 0, 4);
    run_case("R9 R4 start key no run",        0, 0, 1, 0, 4'd0, 0, 0, 0, 1, 5);
    run_case("R8 R9 deposit plus readin",     1, 0, 1, 0, 4'd2, 1, 0, 1, 2, 6);
    run_case("R1 R2 store-E over pause",      1, 1, 0, 0, 4'd9, 1, 0, 0, 3, 7);
    run_case("R6 R8 pause pair no run",       0, 1, 0, 1, 4'd0, 0, 0, 0, 0, 8);
    // R10: stray completion while idle causes nothing
    obs.delete();
    @(negedge clk); stray = 1'b1;
    @(negedge clk); stray = 1'b0;
    repeat (10) @(negedge clk);
    check(obs.size() == 0, "R10 stray done", EVW'(obs.size()), '0);
    run_case("R10 R5 after stray",            0, 0, 0, 0, 4'd12, 1, 0, 0, 0, 9);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule